// File: doc/BRIEF.md
# PPP Octet Escape Encoder/Decoder

This block makes octet-framed PPP-style traffic transparent on a byte-wide link. On transmit it takes payload bytes from a valid/ready stream and marks the last byte of each frame. It puts a flag octet (0x7E) before and after each frame. Any flag, any escape octet (0x7D) and any control character chosen by a 32-bit transmit map goes out as the escape octet followed by the character XOR 0x20. Flow-control characters such as XON (0x11) and XOFF (0x13) can therefore cross a link that would otherwise act on them.

On receive it takes line bytes and strips the flags. It undoes the escaping and returns the payload as a byte stream, with the final byte of each frame marked. Control characters that arrive without an escape and whose bit is set in a 32-bit receive map are discarded, because equipment along the line may have inserted them. A frame that closes right after an escape octet is flagged as aborted.

The block works one octet at a time, so the same logic serves an octet-synchronous line and an asynchronous start/stop line whose character framing is handled elsewhere. Checksum generation and checking are outside the block. Between frames the transmitter either repeats flags or stays silent, as set by a configuration input.

Top module: `ppp_octet_codec`

## Requirements
- R1: Every transmitted frame begins with one 0x7E octet before its first payload octet and ends with one 0x7E octet after its last.
- R2: A payload byte of 0x7E or 0x7D is always sent as 0x7D followed by the byte XOR 0x20 (0x7E becomes 7D 5E, 0x7D becomes 7D 5D), and this also holds for the last byte of a frame.
- R3: A payload byte with value n below 0x20 is sent as 0x7D, n XOR 0x20 when bit n of tx_accm_i is set. It is sent unchanged when that bit is clear. Bytes of 0x20 and above, other than 0x7D and 0x7E, are sent unchanged.
- R4: The line carries at most one octet per cycle. In the cycle after the transmitter accepts a byte that needs escaping, tx_ready_o is low. It returns high one cycle later if the frame continues.
- R5: With no frame pending, the line output carries 0x7E in every cycle when idle_flags_i is 1, and line_tx_valid_o is low when idle_flags_i is 0.
- R6: The receiver strips flags and converts 0x7D x into x XOR 0x20. It delivers payload bytes in order and asserts rx_last_o with the final byte before a closing 0x7E. Empty frames (back-to-back flags) deliver nothing.
- R7: A received byte with value n below 0x20 that does not follow 0x7D is discarded when bit n of rx_accm_i is set. It is delivered when that bit is clear.
- R8: When 0x7D is directly followed by 0x7E, rx_abort_o pulses together with the frame's final byte. If the aborted frame holds no byte, rx_abort_o pulses with rx_valid_o low.
- R9: During and right after reset, tx_ready_o, line_tx_valid_o, rx_valid_o and rx_abort_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_accm_i | input | 32 | Transmit map: bit n set escapes character n |
| rx_accm_i | input | 32 | Receive map: bit n set drops unescaped character n |
| idle_flags_i | input | 1 | 1 = send flags while idle, 0 = silent |
| tx_data_i | input | 8 | Payload byte to send |
| tx_valid_i | input | 1 | Payload byte valid |
| tx_last_i | input | 1 | Payload byte is the last one of its frame |
| tx_ready_o | output | 1 | Transmitter accepts the byte this cycle |
| line_tx_data_o | output | 8 | Octet to the line |
| line_tx_valid_o | output | 1 | Line octet valid |
| line_rx_data_i | input | 8 | Octet from the line |
| line_rx_valid_i | input | 1 | Line octet valid |
| rx_data_o | output | 8 | Recovered payload byte |
| rx_valid_o | output | 1 | Recovered byte valid |
| rx_last_o | output | 1 | Recovered byte ends its frame |
| rx_abort_o | output | 1 | Frame closed directly after an escape |

## Verification
Two pairs of functions can fall in the same cycle. In the transmitter, escape expansion can coincide with frame closing. This is provoked by making the last byte of a frame a flag octet, and it is judged by the exact line sequence 7E 7D 5E 7E and by the ready stall. In the receiver, a closing flag can arrive while an escape is pending. That flag must release the held final byte with both rx_last_o and rx_abort_o set; when no byte is held, it must give a bare abort pulse. A loopback run through the table checks that the receiver restores exactly what the transmitter expanded when both maps are equal.

// File: rtl/ppp_codec_pkg.sv
package ppp_codec_pkg;
  localparam int BYTE_W = 8;
  localparam int MAP_W  = 32;
  localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_OCTET  = 8'h7D;
  localparam logic [BYTE_W-1:0] XOR_MASK   = 8'h20;

  typedef enum logic [1:0] {TX_IDLE, TX_DATA, TX_ESC, TX_CLOSE} tx_state_e;

  function automatic logic is_mapped(input logic [BYTE_W-1:0] b,
                                     input logic [MAP_W-1:0] map);
    return (b < BYTE_W'(MAP_W)) && map[b[$clog2(MAP_W)-1:0]];
  endfunction
endpackage

// File: rtl/ppp_tx_escaper.sv
module ppp_tx_escaper
  import ppp_codec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAP_W-1:0]  map_i,
  input  logic              idle_flags_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic [BYTE_W-1:0] line_data_o,
  output logic              line_valid_o
);
  tx_state_e         state_q, state_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              hold_last_q, hold_last_d;
  logic [BYTE_W-1:0] out_d;
  logic              out_v_d;
  logic              need_esc;

  assign need_esc = (data_i == FLAG_OCTET) || (data_i == ESC_OCTET) || is_mapped(data_i, map_i);
  assign ready_o  = (state_q == TX_DATA);

  always_comb begin
    state_d     = state_q;
    hold_d      = hold_q;
    hold_last_d = hold_last_q;
    out_d       = FLAG_OCTET;
    out_v_d     = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (valid_i) begin
          out_v_d = 1'b1;
          state_d = TX_DATA;
        end else if (idle_flags_i) begin
          out_v_d = 1'b1;
        end
      end
      TX_DATA: begin
        if (valid_i) begin
          out_v_d = 1'b1;
          if (need_esc) begin
            out_d       = ESC_OCTET;
            hold_d      = data_i ^ XOR_MASK;
            hold_last_d = last_i;
            state_d     = TX_ESC;
          end else begin
            out_d   = data_i;
            state_d = last_i ? TX_CLOSE : TX_DATA;
          end
        end
      end
      TX_ESC: begin
        out_v_d = 1'b1;
        out_d   = hold_q;
        state_d = hold_last_q ? TX_CLOSE : TX_DATA;
      end
      default: begin
        out_v_d = 1'b1;
        state_d = TX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= TX_IDLE;
      hold_q       <= '0;
      hold_last_q  <= 1'b0;
      line_data_o  <= '0;
      line_valid_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      hold_q       <= hold_d;
      hold_last_q  <= hold_last_d;
      line_data_o  <= out_d;
      line_valid_o <= out_v_d;
    end
  end

  assert_stall_after_escape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i && need_esc) |=> !ready_o);

  assert_escape_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && line_data_o == ESC_OCTET) |=>
      (line_valid_o && line_data_o != FLAG_OCTET && line_data_o != ESC_OCTET));

  assert_no_raw_mapped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_o && line_data_o < 8'h20) |-> !is_mapped(line_data_o, $past(map_i)));
endmodule

// File: rtl/ppp_rx_unescaper.sv
module ppp_rx_unescaper
  import ppp_codec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MAP_W-1:0]  map_i,
  input  logic [BYTE_W-1:0] line_data_i,
  input  logic              line_valid_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              abort_o
);
  logic              esc_q, esc_d;
  logic [BYTE_W-1:0] held_q, held_d;
  logic              held_v_q, held_v_d;
  logic [BYTE_W-1:0] od;
  logic              ov, ol, oa;
  logic              push;
  logic [BYTE_W-1:0] push_byte;

  always_comb begin
    esc_d     = esc_q;
    push      = 1'b0;
    push_byte = line_data_i;
    ov        = 1'b0;
    ol        = 1'b0;
    oa        = 1'b0;
    od        = held_q;
    if (line_valid_i) begin
      if (line_data_i == FLAG_OCTET) begin
        ov    = held_v_q;
        ol    = held_v_q;
        oa    = esc_q;
        esc_d = 1'b0;
      end else if (esc_q) begin
        esc_d     = 1'b0;
        push      = 1'b1;
        push_byte = line_data_i ^ XOR_MASK;
      end else if (line_data_i == ESC_OCTET) begin
        esc_d = 1'b1;
      end else if (!is_mapped(line_data_i, map_i)) begin
        push = 1'b1;
      end
    end
    // one-byte holdback lets the closing flag tag the final byte
    held_d   = held_q;
    held_v_d = held_v_q;
    if (push) begin
      ov       = held_v_q;
      held_d   = push_byte;
      held_v_d = 1'b1;
    end else if (line_valid_i && line_data_i == FLAG_OCTET) begin
      held_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esc_q    <= 1'b0;
      held_q   <= '0;
      held_v_q <= 1'b0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      last_o   <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      esc_q    <= esc_d;
      held_q   <= held_d;
      held_v_q <= held_v_d;
      data_o   <= od;
      valid_o  <= ov;
      last_o   <= ol;
      abort_o  <= oa;
    end
  end

  assert_abort_on_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(line_valid_i && line_data_i == FLAG_OCTET));

  assert_last_on_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (valid_o && $past(line_valid_i && line_data_i == FLAG_OCTET)));

  assert_drop_mapped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_valid_i && !esc_q && is_mapped(line_data_i, map_i)) |=> !valid_o);
endmodule

// File: rtl/ppp_octet_codec.sv
module ppp_octet_codec
  import ppp_codec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] tx_accm_i,
  input  logic [31:0] rx_accm_i,
  input  logic        idle_flags_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  input  logic        tx_last_i,
  output logic        tx_ready_o,
  output logic [7:0]  line_tx_data_o,
  output logic        line_tx_valid_o,
  input  logic [7:0]  line_rx_data_i,
  input  logic        line_rx_valid_i,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o,
  output logic        rx_last_o,
  output logic        rx_abort_o
);
  ppp_tx_escaper u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .map_i        (tx_accm_i),
    .idle_flags_i (idle_flags_i),
    .data_i       (tx_data_i),
    .valid_i      (tx_valid_i),
    .last_i       (tx_last_i),
    .ready_o      (tx_ready_o),
    .line_data_o  (line_tx_data_o),
    .line_valid_o (line_tx_valid_o)
  );

  ppp_rx_unescaper u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .map_i        (rx_accm_i),
    .line_data_i  (line_rx_data_i),
    .line_valid_i (line_rx_valid_i),
    .data_o       (rx_data_o),
    .valid_o      (rx_valid_o),
    .last_o       (rx_last_o),
    .abort_o      (rx_abort_o)
  );
endmodule

// File: tb/ppp_octet_codec_test.sv
module ppp_octet_codec_test;
  localparam logic [31:0] MAP = 32'h000A_0001;  // 0x00, 0x11, 0x13 mapped
  localparam int NV = 12;
  // {expect_escaped, payload byte}
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'h41}, {1'b1, 8'h7E}, {1'b1, 8'h7D}, {1'b1, 8'h11},
    {1'b1, 8'h13}, {1'b1, 8'h00}, {1'b0, 8'h01}, {1'b0, 8'h20},
    {1'b0, 8'h5E}, {1'b0, 8'h1F}, {1'b0, 8'h12}, {1'b0, 8'hFF}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] tx_accm = MAP, rx_accm = MAP;
  logic idle_flags = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, tx_last = 1'b0, tx_ready;
  logic [7:0] line_tx_data, line_rx_data, drv_data = '0;
  logic line_tx_valid, line_rx_valid, drv_valid = 1'b0;
  logic loop_en = 1'b0, cap_tx = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, rx_last, rx_abort;

  int n_chk = 0, n_fail = 0;
  logic [7:0] txq[$];
  logic [9:0] rxq[$];

  always #2 clk = ~clk;

  assign line_rx_data  = loop_en ? line_tx_data  : drv_data;
  assign line_rx_valid = loop_en ? line_tx_valid : drv_valid;

  ppp_octet_codec uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_accm_i(tx_accm), .rx_accm_i(rx_accm),
    .idle_flags_i(idle_flags), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_last_i(tx_last), .tx_ready_o(tx_ready), .line_tx_data_o(line_tx_data),
    .line_tx_valid_o(line_tx_valid), .line_rx_data_i(line_rx_data),
    .line_rx_valid_i(line_rx_valid), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_last_o(rx_last), .rx_abort_o(rx_abort));

  always @(negedge clk) if (rst_n) begin
    if (cap_tx && line_tx_valid) txq.push_back(line_tx_data);
    if (rx_valid || rx_abort) rxq.push_back({rx_abort, rx_last, rx_data});
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic send_frame(input logic [7:0] b[$]);
    for (int i = 0; i < b.size(); i++) begin
      @(negedge clk);
      tx_valid = 1'b1; tx_data = b[i]; tx_last = (i == b.size() - 1);
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    tx_valid = 1'b0; tx_last = 1'b0;
  endtask

  task automatic drive_line(input logic [7:0] b[$]);
    for (int i = 0; i < b.size(); i++) begin
      @(negedge clk);
      drv_valid = 1'b1; drv_data = b[i];
    end
    @(negedge clk);
    drv_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_rx(input logic [9:0] e[$], input string req);
    chk(rxq.size() == e.size(), req, rxq.size(), e.size());
    for (int i = 0; i < e.size() && i < rxq.size(); i++)
      chk(rxq[i] == e[i], req, rxq[i], e[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    logic [7:0] pay[$];
    logic [7:0] exp[$];
    repeat (3) @(negedge clk);
    chk(!tx_ready && !line_tx_valid && !rx_valid && !rx_abort, "R9 in reset",
        {tx_ready, line_tx_valid, rx_valid, rx_abort}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_ready && !line_tx_valid && !rx_valid && !rx_abort, "R9 after reset",
        {tx_ready, line_tx_valid, rx_valid, rx_abort}, 0);

    // table walk in loopback
    loop_en = 1'b1; cap_tx = 1'b1;
    txq.delete(); rxq.delete(); pay.delete(); exp.delete();
    exp.push_back(8'h7E);
    for (int i = 0; i < NV; i++) begin
      pay.push_back(VEC[i][7:0]);
      if (VEC[i][8]) begin exp.push_back(8'h7D); exp.push_back(VEC[i][7:0] ^ 8'h20); end
      else exp.push_back(VEC[i][7:0]);
    end
    exp.push_back(8'h7E);
    send_frame(pay);
    repeat (8) @(negedge clk);
    chk(txq.size() == exp.size(), "R1 R2 R3 line length", txq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < txq.size(); i++)
      chk(txq[i] == exp[i], "R1 R2 R3 line octet", txq[i], exp[i]);
    chk(rxq.size() == NV, "R6 loopback count", rxq.size(), NV);
    for (int i = 0; i < NV && i < rxq.size(); i++)
      chk(rxq[i] == {1'b0, i == NV - 1, VEC[i][7:0]}, "R6 loopback byte", rxq[i],
          {1'b0, i == NV - 1, VEC[i][7:0]});

    // R4: stall after an escaped byte
    txq.delete(); rxq.delete();
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 8'h13; tx_last = 1'b0;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(tx_ready == 1'b0, "R4 ready low after escape", tx_ready, 0);
    tx_data = 8'h41; tx_last = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R4 ready back", tx_ready, 1);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0; tx_last = 1'b0;
    repeat (6) @(negedge clk);
    exp = '{8'h7E, 8'h7D, 8'h33, 8'h41, 8'h7E};
    chk(txq == exp, "R4 stalled frame on line", txq.size(), exp.size());

    // escape and close in consecutive cycles
    txq.delete(); rxq.delete();
    send_frame('{8'h7E});
    repeat (6) @(negedge clk);
    exp = '{8'h7E, 8'h7D, 8'h5E, 8'h7E};
    chk(txq == exp, "R2 R1 escaped final byte", txq.size(), exp.size());
    expect_rx('{{2'b01, 8'h7E}}, "R6 escaped final byte recovered");

    // R5 idle fill
    idle_flags = 1'b1;
    repeat (2) @(negedge clk);
    chk(line_tx_valid && line_tx_data == 8'h7E, "R5 idle flags", {line_tx_valid, line_tx_data}, 9'h17E);
    idle_flags = 1'b0;
    repeat (2) @(negedge clk);
    chk(!line_tx_valid, "R5 idle silent", line_tx_valid, 0);

    // receive-only cases
    loop_en = 1'b0; cap_tx = 1'b0;
    rxq.delete();
    drive_line('{8'h7E, 8'h41, 8'h11, 8'h42, 8'h7E});
    expect_rx('{{2'b00, 8'h41}, {2'b01, 8'h42}}, "R7 drop unescaped mapped");
    rxq.delete();
    drive_line('{8'h7E, 8'h41, 8'h7D, 8'h31, 8'h7E});
    expect_rx('{{2'b00, 8'h41}, {2'b01, 8'h11}}, "R7 R6 escaped control kept");
    rxq.delete();
    drive_line('{8'h7E, 8'h41, 8'h7D, 8'h7E});
    expect_rx('{{2'b11, 8'h41}}, "R8 abort with final byte");
    rxq.delete();
    drive_line('{8'h7E, 8'h7D, 8'h7E});
    chk(rxq.size() == 1, "R8 bare abort count", rxq.size(), 1);
    if (rxq.size() > 0) chk(rxq[0][9:8] == 2'b10, "R8 bare abort flags", rxq[0][9:8], 2'b10);
    rxq.delete();
    drive_line('{8'h7E, 8'h7E, 8'h7E});
    chk(rxq.size() == 0, "R6 empty frames", rxq.size(), 0);
    rx_accm = 32'h0;
    rxq.delete();
    drive_line('{8'h7E, 8'h11, 8'h7E});
    expect_rx('{{2'b01, 8'h11}}, "R7 unmapped control kept");

    report();
  end
endmodule